// File: doc/BRIEF.md
# Dual Timer/Counter Pair

This block holds two independent 16-bit timer/counters that share one mode byte and one control byte. Each unit either counts an internal tick or counts falling edges seen on its own external count pin. The internal tick is one enable pulse every `TICK_DIV` clock cycles. A unit can also be gated by a level on its gate pin. Four count modes are available: a 13-bit counter with a 5-bit prescaler, a 16-bit counter, an 8-bit counter that reloads itself, and a split mode. In split mode, unit 0 becomes two 8-bit counters and the upper one borrows unit 1's run bit and overflow flag. Unit 1 placed in split mode simply stops and keeps its count.

Software reaches the registers through a single-cycle write port and a combinational read port. Each overflow flag is also an interrupt request output. A flag stays set until the matching acknowledge input clears it.

Top module: `dual_tmr_ctr`

## Requirements
- R1: Register map. Address 0 holds the mode byte: unit 0 in bits 3:0 and unit 1 in bits 7:4. Each nibble has the gate enable in bit 3, external-count select in bit 2, and the mode in bits 1:0 (0 = 13-bit, 1 = 16-bit, 2 = auto-reload, 3 = split/hold). Address 1 is the control byte: run0 in bit 0, run1 in bit 1, flag0 in bit 2 and flag1 in bit 3. Only the run bits are writable. Addresses 2 and 3 are unit 0 low and high; addresses 4 and 5 are unit 1 low and high. Every register resets to 0.
- R2: In timer operation a running unit advances by exactly one per `TICK_DIV` (default 6) clock cycles. Two tick pulses never come on adjacent cycles.
- R3: Mode 0 counts in low bits 4:0 as a modulo-32 prescaler whose carry increments the high byte. Low bits 7:5 are never changed by counting. The overflow is the carry out of 0xFF:0x1F.
- R4: Mode 1 counts high:low as one 16-bit value and overflows on 0xFFFF to 0x0000.
- R5: Mode 2 counts in the low byte. When the low byte overflows it is loaded from the high byte, the flag is set, and the high byte is left unchanged.
- R6: With unit 0 in mode 3, its low byte counts under unit 0's controls and sets flag0. Its high byte counts ticks whenever run1 is set, and its overflow sets flag1.
- R7: Unit 1 in mode 3 holds its count. While unit 0 is in mode 3, an overflow of unit 1 does not set flag1.
- R8: In external-count operation the pin is sampled once per tick. A high sample followed by a low sample at the next tick adds one. The sample history resets to low.
- R9: With the gate bit set, a unit counts only while its run bit is set and its gate pin is high. With the gate bit clear, the run bit alone enables it.
- R10: An overflow sets the unit's flag, and `ovf_flag` mirrors the flags. `ack[i]` clears flag i. An overflow in the same cycle as an acknowledge leaves the flag set.
- R11: Setting a run bit does not clear the count. With the run bit clear, the count stays frozen.
- R12: A write to a count byte on a cycle where that unit would advance stores exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| cnt_pin | input | 2 | External count inputs, one per unit |
| gate_pin | input | 2 | External gate inputs, one per unit |
| ack | input | 2 | Flag acknowledge, one per unit |
| ovf_flag | output | 2 | Overflow flags / interrupt requests |

## Verification
Two pairs of functions can land in the same cycle. The first is a software write to a count byte and a tick increment of that byte. The bench lines up the write with a tick edge by tracking the tick phase from reset, then reads back the byte before the next tick; the written value must appear unmodified. The second is an overflow and an acknowledge of the same flag. The bench starts a unit at 0xFFFF one cycle before a tick and raises the acknowledge on the tick cycle; the flag must remain set, and a later lone acknowledge must clear it.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    localparam int ADDR_W   = 3;
    localparam int BYTE_W   = 8;
    localparam int PRE_W    = 5;
    localparam int N_UNITS  = 2;

    localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_T0L  = 3'd2;
    localparam logic [ADDR_W-1:0] A_T0H  = 3'd3;
    localparam logic [ADDR_W-1:0] A_T1L  = 3'd4;
    localparam logic [ADDR_W-1:0] A_T1H  = 3'd5;

    typedef enum logic [1:0] {
        MODE_13B    = 2'd0,
        MODE_16B    = 2'd1,
        MODE_RELOAD = 2'd2,
        MODE_SPLIT  = 2'd3
    } tc_mode_e;

    typedef struct packed {
        logic     gate;
        logic     ext;
        tc_mode_e mode;
    } tc_cfg_t;

    function automatic logic [ADDR_W-1:0] lo_addr(input int unit);
        return (unit == 0) ? A_T0L : A_T1L;
    endfunction

    function automatic logic [ADDR_W-1:0] hi_addr(input int unit);
        return (unit == 0) ? A_T0H : A_T1H;
    endfunction

endpackage

// File: rtl/dtc_tick_gen.sv
module dtc_tick_gen #(
    parameter int TICK_DIV = 6
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/dtc_src_sel.sv
module dtc_src_sel (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cnt_pin,
    input  logic gate_pin,
    input  logic gate_en,
    input  logic ext_sel,
    input  logic run,
    output logic evt
);
    logic last_q;
    logic fall;
    logic allow;

    always_ff @(posedge clk) begin
        if (rst)       last_q <= 1'b0;
        else if (tick) last_q <= cnt_pin;
    end

    assign fall  = last_q & ~cnt_pin;
    assign allow = run & (~gate_en | gate_pin);
    assign evt   = tick & allow & (ext_sel ? fall : 1'b1);
endmodule

// File: rtl/dtc_unit.sv
module dtc_unit
    import dtc_pkg::*;
#(
    parameter bit CAN_SPLIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  tc_mode_e          mode,
    input  logic              evt,
    input  logic              hi_evt,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              ovf_main,
    output logic              ovf_hi
);
    logic [BYTE_W-1:0] lo_n, hi_n;
    logic split, main_inc, hi_inc;

    assign split    = (mode == MODE_SPLIT);
    assign main_inc = evt & ~wr_lo & ~(wr_hi & ~split) & (CAN_SPLIT | ~split);
    assign hi_inc   = hi_evt & ~wr_hi & split & CAN_SPLIT;

    always_comb begin
        lo_n     = lo;
        hi_n     = hi;
        ovf_main = 1'b0;
        ovf_hi   = 1'b0;
        if (main_inc) begin
            case (mode)
                MODE_13B: begin
                    lo_n[PRE_W-1:0] = lo[PRE_W-1:0] + 1'b1;
                    if (&lo[PRE_W-1:0]) begin
                        hi_n     = hi + 1'b1;
                        ovf_main = &hi;
                    end
                end
                MODE_16B: begin
                    {hi_n, lo_n} = {hi, lo} + 1'b1;
                    ovf_main     = &{hi, lo};
                end
                MODE_RELOAD: begin
                    if (&lo) begin
                        lo_n     = hi;
                        ovf_main = 1'b1;
                    end else begin
                        lo_n = lo + 1'b1;
                    end
                end
                default: begin
                    lo_n     = lo + 1'b1;
                    ovf_main = &lo;
                end
            endcase
        end
        if (hi_inc) begin
            hi_n   = hi + 1'b1;
            ovf_hi = &hi;
        end
        if (wr_lo) lo_n = wdata;
        if (wr_hi) hi_n = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= lo_n;
            hi <= hi_n;
        end
    end
endmodule

// File: rtl/dual_tmr_ctr.sv
module dual_tmr_ctr
    import dtc_pkg::*;
#(
    parameter int TICK_DIV = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [1:0]        cnt_pin,
    input  logic [1:0]        gate_pin,
    input  logic [1:0]        ack,
    output logic [1:0]        ovf_flag
);
    tc_cfg_t     cfg_q [N_UNITS];
    logic [1:0]  run_q;
    logic [1:0]  flag_q;
    logic [1:0]  set_flag;
    logic        tick;
    logic        wr_cfg, wr_ctrl;
    logic [1:0]  evt, hi_evt, ovf_main, ovf_hi;
    logic [BYTE_W-1:0] cnt_lo [N_UNITS];
    logic [BYTE_W-1:0] cnt_hi [N_UNITS];

    dtc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    assign wr_cfg  = wr_en && (wr_addr == A_CFG);
    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign hi_evt  = {1'b0, tick & run_q[1]};

    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
        logic wr_lo_i, wr_hi_i;
        assign wr_lo_i = wr_en && (wr_addr == lo_addr(i));
        assign wr_hi_i = wr_en && (wr_addr == hi_addr(i));

        dtc_src_sel u_src (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .cnt_pin (cnt_pin[i]),
            .gate_pin(gate_pin[i]),
            .gate_en (cfg_q[i].gate),
            .ext_sel (cfg_q[i].ext),
            .run     (run_q[i]),
            .evt     (evt[i])
        );

        dtc_unit #(.CAN_SPLIT(i == 0)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .mode    (cfg_q[i].mode),
            .evt     (evt[i]),
            .hi_evt  (hi_evt[i]),
            .wr_lo   (wr_lo_i),
            .wr_hi   (wr_hi_i),
            .wdata   (wr_data),
            .lo      (cnt_lo[i]),
            .hi      (cnt_hi[i]),
            .ovf_main(ovf_main[i]),
            .ovf_hi  (ovf_hi[i])
        );
    end

    assign set_flag[0] = ovf_main[0];
    assign set_flag[1] = ovf_hi[0] | (ovf_main[1] & (cfg_q[0].mode != MODE_SPLIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q[0] <= '0;
            cfg_q[1] <= '0;
            run_q    <= '0;
            flag_q   <= '0;
        end else begin
            if (wr_cfg) begin
                cfg_q[0] <= tc_cfg_t'(wr_data[3:0]);
                cfg_q[1] <= tc_cfg_t'(wr_data[7:4]);
            end
            if (wr_ctrl) run_q <= wr_data[1:0];
            flag_q <= (flag_q & ~ack) | set_flag;
        end
    end

    always_comb begin
        case (rd_addr)
            A_CFG:   rd_data = {cfg_q[1], cfg_q[0]};
            A_CTRL:  rd_data = {4'b0000, flag_q, run_q};
            A_T0L:   rd_data = cnt_lo[0];
            A_T0H:   rd_data = cnt_hi[0];
            A_T1L:   rd_data = cnt_lo[1];
            A_T1H:   rd_data = cnt_hi[1];
            default: rd_data = '0;
        endcase
    end

    assign ovf_flag = flag_q;
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker
    import dtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [1:0]        run_q,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic [1:0]        ack,
    input logic [1:0]        set_flag,
    input logic [1:0]        flag_q,
    input tc_mode_e          mode1,
    input logic [BYTE_W-1:0] lo0,
    input logic [BYTE_W-1:0] lo1,
    input logic [BYTE_W-1:0] hi1
);
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    assert_t1_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mode1 == MODE_SPLIT) && !(wr_en && (wr_addr == A_T1L || wr_addr == A_T1H))
        |=> $stable(lo1) && $stable(hi1));

    assert_ack_clear_R10: assert property (@(posedge clk) disable iff (rst)
        ack[0] && !set_flag[0] |=> !flag_q[0]);

    assert_set_flag_R10: assert property (@(posedge clk) disable iff (rst)
        set_flag[1] |=> flag_q[1]);

    assert_run_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        !run_q[0] && !(wr_en && wr_addr == A_T0L) |=> $stable(lo0));

    assert_write_wins_R12: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wr_addr == A_T0L) |=> lo0 == $past(wr_data));
endmodule

bind dual_tmr_ctr dtc_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .run_q   (run_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ack     (ack),
    .set_flag(set_flag),
    .flag_q  (flag_q),
    .mode1   (cfg_q[1].mode),
    .lo0     (cnt_lo[0]),
    .lo1     (cnt_lo[1]),
    .hi1     (cnt_hi[1])
);

// File: tb/tb_dual_tmr_ctr.sv
`timescale 1ns/1ps
module tb_dual_tmr_ctr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] cnt_pin = '0;
    logic [1:0] gate_pin = '0;
    logic [1:0] ack = '0;
    logic [1:0] ovf_flag;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int bk = 0;

    dual_tmr_ctr dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .ack(ack), .ovf_flag(ovf_flag)
    );

    always #2.5 clk = ~clk;

    // edges since reset release; tick edges are those where bk % 6 == 5 before the edge
    always @(posedge clk) begin
        if (rst) bk <= 0;
        else     bk <= bk + 1;
    end

    typedef struct packed {
        logic [7:0] cfg;
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] ticks;
        logic [7:0] elo;
        logic [7:0] ehi;
        logic       eflag;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'h01, 8'h00, 8'h00, 8'd10, 8'h0A, 8'h00, 1'b0},
        '{8'h01, 8'hFE, 8'h00, 8'd3,  8'h01, 8'h01, 1'b0},
        '{8'h01, 8'hFE, 8'hFF, 8'd3,  8'h01, 8'h00, 1'b1},
        '{8'h00, 8'hFE, 8'h00, 8'd3,  8'hE1, 8'h01, 1'b0},
        '{8'h00, 8'h1F, 8'hFF, 8'd1,  8'h00, 8'h00, 1'b1},
        '{8'h02, 8'hFD, 8'h80, 8'd4,  8'h81, 8'h80, 1'b1},
        '{8'h02, 8'h10, 8'hAA, 8'd5,  8'h15, 8'hAA, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic clr_flags();
        ack = 2'b11; @(posedge clk); #1; ack = 2'b00;
    endtask

    // exactly n ticks fall inside a run window of 6n edges
    task automatic run_ticks(input logic [7:0] ctrl, input int n);
        bus_wr(3'd1, ctrl);
        repeat (6 * n - 1) @(posedge clk);
        #1;
        bus_wr(3'd1, 8'h00);
    endtask

    logic [7:0] r, r2;

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            bus_rd(3'(a), r);
            chk("R1 reset register", {8'h0, r}, 16'h0);
        end
        chk("R1 reset flags", {14'h0, ovf_flag}, 16'h0);

        // vector table: unit 0 in modes 0..2 (R2 R3 R4 R5 R11)
        foreach (VECS[i]) begin
            clr_flags();
            bus_wr(3'd0, VECS[i].cfg);
            bus_wr(3'd2, VECS[i].lo);
            bus_wr(3'd3, VECS[i].hi);
            run_ticks(8'h01, int'(VECS[i].ticks));
            bus_rd(3'd2, r);  chk("R2/R3/R4/R5 low byte", {8'h0, r}, {8'h0, VECS[i].elo});
            bus_rd(3'd3, r);  chk("R3/R4/R5/R11 high byte", {8'h0, r}, {8'h0, VECS[i].ehi});
            bus_rd(3'd1, r);  chk("R10 flag0 in control", {15'h0, r[2]}, {15'h0, VECS[i].eflag});
            chk("R10 ovf_flag port", {15'h0, ovf_flag[0]}, {15'h0, VECS[i].eflag});
        end

        // R11: run bit clear keeps count frozen
        repeat (20) @(posedge clk); #1;
        bus_rd(3'd2, r); chk("R11 frozen while stopped", {8'h0, r}, 16'h0015);

        // R6: unit 0 split mode
        clr_flags();
        bus_wr(3'd0, 8'h03);
        bus_wr(3'd2, 8'hFE); bus_wr(3'd3, 8'hFE);
        bus_wr(3'd4, 8'h00); bus_wr(3'd5, 8'h00);
        run_ticks(8'h01, 3);
        bus_rd(3'd2, r);  chk("R6 split low counts", {8'h0, r}, 16'h0001);
        bus_rd(3'd3, r);  chk("R6 split high idle without run1", {8'h0, r}, 16'h00FE);
        chk("R6 flags after low overflow", {14'h0, ovf_flag}, 16'h0001);
        clr_flags();
        run_ticks(8'h02, 3);
        bus_rd(3'd3, r);  chk("R6 split high counts on run1", {8'h0, r}, 16'h0001);
        bus_rd(3'd2, r);  chk("R6 split low idle", {8'h0, r}, 16'h0001);
        chk("R6 high overflow sets flag1", {14'h0, ovf_flag}, 16'h0002);

        // R7: unit 1 overflow does not reach flag1 while unit 0 is split
        clr_flags();
        bus_wr(3'd0, 8'h13);
        bus_wr(3'd3, 8'h00);
        bus_wr(3'd4, 8'hFF); bus_wr(3'd5, 8'hFF);
        run_ticks(8'h02, 1);
        bus_rd(3'd4, r); bus_rd(3'd5, r2);
        chk("R7 unit1 wrapped", {r2, r}, 16'h0000);
        chk("R7 flag1 not set by unit1", {14'h0, ovf_flag}, 16'h0000);

        // R7: unit 1 mode 3 holds
        bus_wr(3'd0, 8'h30);
        bus_wr(3'd4, 8'h55); bus_wr(3'd5, 8'h66);
        run_ticks(8'h02, 3);
        bus_rd(3'd4, r); bus_rd(3'd5, r2);
        chk("R7 unit1 holds in mode 3", {r2, r}, 16'h6655);

        // R8: external falling edges on unit 1
        bus_wr(3'd0, 8'h50);
        bus_wr(3'd4, 8'h00); bus_wr(3'd5, 8'h00);
        bus_wr(3'd1, 8'h02);
        for (int p = 0; p < 3; p++) begin
            cnt_pin[1] = 1'b1; repeat (12) @(posedge clk); #1;
            cnt_pin[1] = 1'b0; repeat (12) @(posedge clk); #1;
        end
        bus_wr(3'd1, 8'h00);
        bus_rd(3'd4, r); bus_rd(3'd5, r2);
        chk("R8 three falling edges counted", {r2, r}, 16'h0003);
        bus_rd(3'd2, r);
        chk("R8 unit0 unaffected", {8'h0, r}, 16'h0001);

        // R9: gate
        bus_wr(3'd0, 8'h09);
        bus_wr(3'd2, 8'h00); bus_wr(3'd3, 8'h00);
        gate_pin[0] = 1'b0;
        run_ticks(8'h01, 4);
        bus_rd(3'd2, r); chk("R9 gate low blocks", {8'h0, r}, 16'h0000);
        gate_pin[0] = 1'b1;
        run_ticks(8'h01, 4);
        bus_rd(3'd2, r); chk("R9 gate high counts", {8'h0, r}, 16'h0004);
        gate_pin[0] = 1'b0;

        // R12: write on a tick edge wins
        bus_wr(3'd0, 8'h01);
        bus_wr(3'd1, 8'h01);
        do @(negedge clk); while ((bk % 6) != 5);
        bus_wr(3'd2, 8'h40);
        @(negedge clk);
        bus_rd(3'd2, r); chk("R12 write beats increment", {8'h0, r}, 16'h0040);
        bus_wr(3'd1, 8'h00);

        // R10: overflow and acknowledge in the same cycle
        clr_flags();
        bus_wr(3'd2, 8'hFF); bus_wr(3'd3, 8'hFF);
        do @(negedge clk); while ((bk % 6) != 4);
        bus_wr(3'd1, 8'h01);
        @(negedge clk);
        ack[0] = 1'b1;
        @(posedge clk); #1; ack[0] = 1'b0;
        @(negedge clk);
        chk("R10 overflow wins over ack", {15'h0, ovf_flag[0]}, 16'h0001);
        bus_wr(3'd1, 8'h00);
        ack[0] = 1'b1; @(posedge clk); #1; ack[0] = 1'b0;
        @(negedge clk);
        chk("R10 ack clears flag0", {15'h0, ovf_flag[0]}, 16'h0000);
        bus_rd(3'd1, r); chk("R1 control readback", {8'h0, r}, 16'h0000);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule